// File: doc/BRIEF.md
# Staggered Test-Enable Sequencer

This controller drives a scan test on a design that has several scan chains. Each chain has its own test-enable line, and every chain shifts in parallel. When shifting ends, the chains leave test mode one per clock instead of all at once. When the capture pulse or pulses are over, they return to test mode the same way. Spreading these edges over time spreads the switching of the gating elements and keeps the peak supply current low.

The same sequence drives the control of the latches that block captured values. A two-pulse launch-off-capture mode is supported. A run is started with a shift length, a pattern count and a mode. The block then repeats shift, stagger-off, capture and stagger-on once per pattern, and signals completion with a single-cycle done pulse. Pattern data is not part of this block.

Top module: `stagger_te_seq`

## Requirements
- R1: Out of reset and while idle, every `te` bit is 1 and `shift_en`, `cap_en`, `latch_hold` and `done` are 0.
- R2: A `start` seen while idle begins a run. For `shift_len` cycles (a value of 0 counts as 1), `shift_en` is 1 and every `te` bit is 1.
- R3: After shifting, the chains leave test mode over NCHAIN cycles. In the k-th of these cycles (counting from 0), `te[i]` is 0 for i <= k and 1 otherwise, so at most one `te` bit changes per clock.
- R4: After the last chain has dropped, `cap_en` is 1 for one cycle when `mode[0]` is 0, or for two consecutive cycles when `mode[0]` is 1. During capture every `te` bit is 0, so all chains capture in the same cycle.
- R5: `cap_en` is never 1 in the cycle that follows a cycle with `shift_en` at 1.
- R6: After capture, the chains return to test mode over NCHAIN cycles. In the k-th of these cycles, `te[i]` is 1 for i <= k and 0 otherwise.
- R7: `shift_en` is 1 only while every `te` bit is 1.
- R8: When `mode[1]` is 1, `latch_hold` is 1 from the first stagger-off cycle of a pattern through stagger-on, and through the whole shift of every later pattern. It is 0 during the first pattern's shift, on done and while idle. When `mode[1]` is 0, `latch_hold` stays 0.
- R9: A run processes `num_pat` patterns (a value of 0 counts as 1). After the last stagger-on, `done` is 1 for exactly one cycle, and the block is then idle.
- R10: `start` has no effect while a run is in progress or while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| shift_len | input | LENW | Shift cycles per pattern (0 means 1) |
| num_pat | input | PATW | Patterns per run (0 means 1) |
| mode | input | 2 | Bit 0: two-pulse capture; bit 1: blocked capture |
| te | output | NCHAIN | Per-chain test-enable, 1 = shift mode |
| shift_en | output | 1 | Shift clock enable |
| cap_en | output | 1 | Capture clock enable |
| latch_hold | output | 1 | Capture-blocking latches closed |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Random runs vary the shift length (including 0), the pattern count (1 to 3) and all four mode values. They show whether the shift window ends on the right cycle, whether the one-pulse and two-pulse capture paths differ, and whether the latch hold is absent from the first shift but present in later ones. Each cycle is compared with an expected output vector built from nested loops over patterns, stagger steps and pulses. This exposes any step that is off by one, in either stagger direction. `start` is toggled at random during every run, so a busy-time restart would shift the whole timeline and be caught.

// File: rtl/stagger_te_seq.sv
module stagger_te_seq #(
  parameter int NCHAIN = 4,
  parameter int LENW   = 8,
  parameter int PATW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LENW-1:0]   shift_len,
  input  logic [PATW-1:0]   num_pat,
  input  logic [1:0]        mode,
  output logic [NCHAIN-1:0] te,
  output logic              shift_en,
  output logic              cap_en,
  output logic              latch_hold,
  output logic              done
);
  localparam int SW = (NCHAIN > 1) ? $clog2(NCHAIN) : 1;
  localparam logic [SW-1:0] LAST = SW'(NCHAIN - 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_OFF, S_CAP, S_ON, S_DONE} st_t;

  st_t             st;
  logic [LENW-1:0] cnt, len_q;
  logic [PATW-1:0] pat_left;
  logic [SW-1:0]   step;
  logic            second, loc_q, blk_q, first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      len_q    <= '0;
      pat_left <= '0;
      step     <= '0;
      second   <= 1'b0;
      loc_q    <= 1'b0;
      blk_q    <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          len_q    <= (shift_len == '0) ? LENW'(1) : shift_len;
          cnt      <= (shift_len == '0) ? LENW'(1) : shift_len;
          pat_left <= (num_pat == '0) ? PATW'(1) : num_pat;
          loc_q    <= mode[0];
          blk_q    <= mode[1];
          first_q  <= 1'b1;
          st       <= S_SHIFT;
        end
        S_SHIFT: begin
          if (cnt == LENW'(1)) begin
            st   <= S_OFF;
            step <= '0;
          end else begin
            cnt <= cnt - LENW'(1);
          end
        end
        S_OFF: begin
          if (step == LAST) begin
            st     <= S_CAP;
            second <= 1'b0;
          end else begin
            step <= step + SW'(1);
          end
        end
        S_CAP: begin
          if (loc_q && !second) begin
            second <= 1'b1;
          end else begin
            st   <= S_ON;
            step <= '0;
          end
        end
        S_ON: begin
          if (step == LAST) begin
            if (pat_left == PATW'(1)) begin
              st <= S_DONE;
            end else begin
              pat_left <= pat_left - PATW'(1);
              cnt      <= len_q;
              first_q  <= 1'b0;
              st       <= S_SHIFT;
            end
          end else begin
            step <= step + SW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NCHAIN; i++) begin
      case (st)
        S_OFF:   te[i] = (i > int'(step));
        S_ON:    te[i] = (i <= int'(step));
        S_CAP:   te[i] = 1'b0;
        default: te[i] = 1'b1;
      endcase
    end
  end

  assign shift_en   = (st == S_SHIFT);
  assign cap_en     = (st == S_CAP);
  assign done       = (st == S_DONE);
  assign latch_hold = blk_q && ((st == S_OFF) || (st == S_CAP) || (st == S_ON) ||
                                ((st == S_SHIFT) && !first_q));
endmodule

// File: rtl/stagger_te_seq_chk.sv
module stagger_te_seq_chk #(
  parameter int NCHAIN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCHAIN-1:0] te,
  input logic              shift_en,
  input logic              cap_en,
  input logic              latch_hold,
  input logic              done
);
  a_r7_shift_needs_all_te: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (&te));
  a_r4_capture_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (te == '0));
  a_r3_one_chain_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(te ^ $past(te)) <= 1));
  a_r5_no_launch_off_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !cap_en);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_hold_open_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !latch_hold);
endmodule

bind stagger_te_seq stagger_te_seq_chk #(.NCHAIN(NCHAIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .te(te), .shift_en(shift_en), .cap_en(cap_en),
  .latch_hold(latch_hold), .done(done));

// File: tb/tb_stagger_te_seq.sv
module tb_stagger_te_seq;
  localparam int N = 4;
  localparam int LENW = 8;
  localparam int PATW = 4;
  localparam int VW = N + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LENW-1:0] shift_len = '0;
  logic [PATW-1:0] num_pat = '0;
  logic [1:0] mode = '0;
  logic [N-1:0] te;
  logic shift_en, cap_en, latch_hold, done;

  int checks = 0;
  int errors = 0;
  int seed_sink;

  always #5 clk = ~clk;

  stagger_te_seq #(.NCHAIN(N), .LENW(LENW), .PATW(PATW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .shift_len(shift_len),
    .num_pat(num_pat), .mode(mode), .te(te), .shift_en(shift_en),
    .cap_en(cap_en), .latch_hold(latch_hold), .done(done));

  function automatic logic [VW-1:0] pack(logic [N-1:0] t, logic s, logic c, logic h, logic d);
    return {t, s, c, h, d};
  endfunction

  function automatic logic [N-1:0] off_mask(int k);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (i > k);
    return m;
  endfunction

  function automatic logic [N-1:0] on_mask(int k);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (i <= k);
    return m;
  endfunction

  task automatic chk(string req, logic [VW-1:0] exp);
    logic [VW-1:0] act;
    act = pack(te, shift_en, cap_en, latch_hold, done);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {te,shift,cap,hold,done} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step_cycle(logic allow_start);
    start = allow_start ? 1'($urandom % 2) : 1'b0;
    @(negedge clk);
  endtask

  task automatic run(int len, int np, logic [1:0] md);
    int eff_len, eff_np;
    logic blk;
    eff_len = (len == 0) ? 1 : len;
    eff_np  = (np == 0) ? 1 : np;
    blk = md[1];
    shift_len = LENW'(len);
    num_pat = PATW'(np);
    mode = md;
    start = 1'b1;
    @(negedge clk);
    for (int p = 0; p < eff_np; p++) begin
      for (int s = 0; s < eff_len; s++) begin
        chk("R2 R8 R10 shift", pack('1, 1'b1, 1'b0, blk && (p > 0), 1'b0));
        step_cycle(1'b1);
      end
      for (int k = 0; k < N; k++) begin
        chk("R3 R5 stagger-off", pack(off_mask(k), 1'b0, 1'b0, blk, 1'b0));
        step_cycle(1'b1);
      end
      for (int c = 0; c < (md[0] ? 2 : 1); c++) begin
        chk("R4 R8 capture", pack('0, 1'b0, 1'b1, blk, 1'b0));
        step_cycle(1'b1);
      end
      for (int k = 0; k < N; k++) begin
        chk("R6 stagger-on", pack(on_mask(k), 1'b0, 1'b0, blk, 1'b0));
        step_cycle(1'b1);
      end
    end
    chk("R9 done", pack('1, 1'b0, 1'b0, 1'b0, 1'b1));
    step_cycle(1'b0);
    chk("R9 R1 idle after done", pack('1, 1'b0, 1'b0, 1'b0, 1'b0));
    step_cycle(1'b0);
  endtask

  initial begin
    seed_sink = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    chk("R1 reset", pack('1, 1'b0, 1'b0, 1'b0, 1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", pack('1, 1'b0, 1'b0, 1'b0, 1'b0));

    run(0, 1, 2'b00);
    run(1, 0, 2'b01);
    run(3, 2, 2'b10);
    run(5, 3, 2'b11);
    run(255, 1, 2'b00);
    for (int r = 0; r < 40; r++) begin
      run(int'($urandom % 11), int'($urandom % 3) + 1, 2'($urandom % 4));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule